// File: doc/BRIEF.md
# Bus Loopback Test Register

This block gives a host microcontroller a way to prove every line of the asynchronous external-memory link to an FPGA. Behind an SRAM-style slave port it holds one 32-bit register. Reads return the register contents at any address. A write to word address zero stores the write data. A write to any other word address stores that address instead, so the same register exercises both the data lines and the address lines.

The host drives active-low chip select, write enable and output enable, a word address, and separate inbound and outbound data lanes. A tristate pad outside the block uses the data output and its enable. The control strobes pass through two-flop synchronisers into the FPGA clock. The block captures address and data when the write strobe begins. It commits them when the strobe ends, so each bus write gives exactly one register update.

Top module: `bus_loopback_reg`

## Requirements
- R1: After synchronous reset the register holds zero, and a read returns 0x00000000.
- R2: A write whose word address is zero loads the 32-bit write data into the register.
- R3: A write whose word address is non-zero loads that address, zero-extended into the low-order bits, and discards the data. For example, word address 0x123456 reads back as 0x00123456.
- R4: A read returns the register contents whatever address is presented. Reads never alter the register.
- R5: The data output enable is high only while chip select and output enable are both low after synchronisation. While it is low the data output is all zeros.
- R6: A write commits only when write enable is released. While the strobe is held, the register keeps its old value, and one strobe gives one update.
- R7: Address and data are captured when the write strobe begins. Changes on the data lines later in the same strobe have no effect.
- R8: A write strobe with chip select inactive (high) leaves the register unchanged.
- R9: When a read is held across a write commit, the output shows the old value before the commit and the new value after it, with no gap in the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FPGA system clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low, asynchronous |
| bus_we_n | input | 1 | Write strobe, active low, asynchronous |
| bus_oe_n | input | 1 | Output enable, active low, asynchronous |
| bus_addr | input | ADDR_W (24) | Word address from the host |
| bus_din | input | DATA_W (32) | Write data from the host |
| bus_dout | output | DATA_W (32) | Registered read data to the pad |
| bus_dout_en | output | 1 | Registered pad drive enable |

## Verification
The read path and the write commit can land in the same cycle. This happens when the host keeps chip select and output enable low through a whole write strobe. The bench provokes it by opening a read, starting a zero-address write inside it, and sampling the output both before and after releasing the write strobe. It judges that the old value shows first, the new value follows, and the enable stays high throughout. A second case holds the strobe and changes the data lines part-way through, to show that the capture at the start of the strobe wins.

// File: rtl/bus_loopback_pkg.sv
package bus_loopback_pkg;
  parameter int LB_DATA_W = 32;
  parameter int LB_ADDR_W = 24;
  parameter int LB_SYNC_STAGES = 2;

  // control bit positions in the synchronised strobe vector
  localparam int CTL_CS = 0;
  localparam int CTL_WE = 1;
  localparam int CTL_OE = 2;
  localparam int CTL_N  = 3;
endpackage

// File: rtl/bl_sync.sv
module bl_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= RST_VAL;
          else     stage[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= RST_VAL;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/bl_strobe_ctrl.sv
module bl_strobe_ctrl #(
  parameter int DW = 32,
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s_n,
  input  logic          we_s_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          commit,
  output logic [AW-1:0] cap_addr,
  output logic [DW-1:0] cap_data
);
  logic we_q_n;
  logic armed;
  logic strobe_start;
  logic strobe_end;

  assign strobe_start = we_q_n & ~we_s_n;
  assign strobe_end   = ~we_q_n & we_s_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q_n   <= 1'b1;
      armed    <= 1'b0;
      commit   <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      we_q_n <= we_s_n;
      commit <= 1'b0;
      if (strobe_start && !cs_s_n) begin
        armed    <= 1'b1;
        cap_addr <= addr;
        cap_data <= din;
      end
      if (strobe_end && armed) begin
        commit <= 1'b1;
        armed  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bl_loop_reg.sv
module bl_loop_reg #(
  parameter int DW = 32,
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit,
  input  logic [AW-1:0] cap_addr,
  input  logic [DW-1:0] cap_data,
  output logic [DW-1:0] stored
);
  localparam int PAD_W = DW - AW;

  logic [DW-1:0] next_val;

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb next_val = (cap_addr == '0) ? cap_data : {{PAD_W{1'b0}}, cap_addr};
    end else begin : g_nopad
      always_comb next_val = (cap_addr == '0) ? cap_data : cap_addr[DW-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         stored <= '0;
    else if (commit) stored <= next_val;
  end
endmodule

// File: rtl/bl_read_drive.sv
module bl_read_drive #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s_n,
  input  logic          oe_s_n,
  input  logic [DW-1:0] stored,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  logic drive;
  assign drive = ~cs_s_n & ~oe_s_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout_en <= drive;
      dout    <= drive ? stored : '0;
    end
  end
endmodule

// File: rtl/bus_loopback_reg.sv
module bus_loopback_reg
  import bus_loopback_pkg::*;
#(
  parameter int DATA_W = LB_DATA_W,
  parameter int ADDR_W = LB_ADDR_W,
  parameter int SYNC_STAGES = LB_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en
);
  logic [CTL_N-1:0]  ctl_raw;
  logic [CTL_N-1:0]  ctl_s;
  logic              cs_s_n;
  logic              we_s_n;
  logic              oe_s_n;
  logic              commit;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic [DATA_W-1:0] stored;

  always_comb begin
    ctl_raw         = '1;
    ctl_raw[CTL_CS] = bus_cs_n;
    ctl_raw[CTL_WE] = bus_we_n;
    ctl_raw[CTL_OE] = bus_oe_n;
  end

  bl_sync #(.W(CTL_N), .STAGES(SYNC_STAGES), .RST_VAL({CTL_N{1'b1}})) u_sync (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
  );

  assign cs_s_n = ctl_s[CTL_CS];
  assign we_s_n = ctl_s[CTL_WE];
  assign oe_s_n = ctl_s[CTL_OE];

  bl_strobe_ctrl #(.DW(DATA_W), .AW(ADDR_W)) u_strobe (
    .clk(clk), .rst(rst), .cs_s_n(cs_s_n), .we_s_n(we_s_n),
    .addr(bus_addr), .din(bus_din),
    .commit(commit), .cap_addr(cap_addr), .cap_data(cap_data)
  );

  bl_loop_reg #(.DW(DATA_W), .AW(ADDR_W)) u_reg (
    .clk(clk), .rst(rst), .commit(commit),
    .cap_addr(cap_addr), .cap_data(cap_data), .stored(stored)
  );

  bl_read_drive #(.DW(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .cs_s_n(cs_s_n), .oe_s_n(oe_s_n),
    .stored(stored), .dout(bus_dout), .dout_en(bus_dout_en)
  );
endmodule

// File: rtl/bus_loopback_chk.sv
module bus_loopback_chk #(
  parameter int DW = 32,
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_s_n,
  input logic          oe_s_n,
  input logic          commit,
  input logic [AW-1:0] cap_addr,
  input logic [DW-1:0] cap_data,
  input logic [DW-1:0] stored,
  input logic [DW-1:0] bus_dout,
  input logic          bus_dout_en
);
  p_reset_zero_r1: assert property (@(posedge clk) rst |=> stored == '0);

  p_zero_addr_data_r2: assert property (@(posedge clk) disable iff (rst)
    (commit && cap_addr == '0) |=> stored == $past(cap_data));

  p_nonzero_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (commit && cap_addr != '0) |=> stored == DW'($past(cap_addr)));

  p_hold_no_commit_r4: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(stored));

  p_drive_gate_r5: assert property (@(posedge clk) disable iff (rst)
    bus_dout_en |-> $past(!cs_s_n && !oe_s_n));

  p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !bus_dout_en |-> bus_dout == '0);

  p_single_commit_r6: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);
endmodule

bind bus_loopback_reg bus_loopback_chk #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cs_s_n(cs_s_n), .oe_s_n(oe_s_n), .commit(commit),
  .cap_addr(cap_addr), .cap_data(cap_data), .stored(stored),
  .bus_dout(bus_dout), .bus_dout_en(bus_dout_en)
);

// File: tb/tb_bus_loopback_reg.sv
module tb_bus_loopback_reg;
  localparam int DW = 32;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1;
  logic          we_n = 1'b1;
  logic          oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;

  int checks = 0;
  int fails = 0;
  logic tick = 1'b0;

  typedef struct {
    logic [DW-1:0] val;
    string         req;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  bus_loopback_reg #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
    .bus_addr(addr), .bus_din(din), .bus_dout(dout), .bus_dout_en(dout_en)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side of the scoreboard: queue the expectation, then signal monitor
  task automatic expect_now(input logic [DW-1:0] v, input string req);
    exp_q.push_back('{val: v, req: req});
    tick = ~tick;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit sel);
    addr = a; din = d; cs_n = ~sel;
    cyc(1); we_n = 1'b0;
    cyc(4); we_n = 1'b1;
    cyc(1); cs_n = 1'b1;
    cyc(6);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] v, input string req);
    addr = a; cs_n = 1'b0; oe_n = 1'b0;
    cyc(6);
    expect_now(v, req);
    cyc(1);
    oe_n = 1'b1; cs_n = 1'b1;
    cyc(5);
  endtask

  // monitor side: pop and compare against the output pins
  initial begin
    forever begin
      @(tick);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.req, " data"}, dout, e.val);
        chk({e.req, " enable"}, DW'(dout_en), DW'(1));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(3);
    // R5 idle: no drive and zero data after reset
    chk("R5 idle enable", DW'(dout_en), '0);
    chk("R5 idle data", dout, '0);
    // R1 reset value
    bus_read(24'h000000, 32'h0, "R1 reset value");

    // R2 several data patterns at word address zero
    bus_write(24'h0, 32'hA5A5_5A5A, 1'b1);
    bus_read(24'h0, 32'hA5A5_5A5A, "R2 pattern a5");
    bus_write(24'h0, 32'hFFFF_FFFF, 1'b1);
    bus_read(24'h0, 32'hFFFF_FFFF, "R2 all ones");
    for (int i = 0; i < 32; i += 9) begin
      bus_write(24'h0, 32'h1 << i, 1'b1);
      bus_read(24'h0, 32'h1 << i, "R2 walking one");
    end

    // R3 address stored, zero-extended, data discarded
    bus_write(24'h123456, 32'hDEAD_BEEF, 1'b1);
    bus_read(24'h0, 32'h0012_3456, "R3 mid address");
    bus_write(24'hFFFFFF, 32'h0, 1'b1);
    bus_read(24'h0, 32'h00FF_FFFF, "R3 top address");
    bus_write(24'h000001, 32'hFFFF_FFFF, 1'b1);
    bus_read(24'h0, 32'h0000_0001, "R3 lowest address");

    // R4 reads at different addresses return the same value, no side effect
    bus_read(24'hABCDEF, 32'h0000_0001, "R4 read other address");
    bus_read(24'h000002, 32'h0000_0001, "R4 repeat read");

    // R8 strobe without chip select
    bus_write(24'h0, 32'h1234_5678, 1'b0);
    bus_read(24'h0, 32'h0000_0001, "R8 no chip select");

    // R7 data changed mid strobe is ignored
    addr = 24'h0; din = 32'hCAFE_0001; cs_n = 1'b0;
    cyc(1); we_n = 1'b0;
    cyc(4); din = 32'h0BAD_0BAD;
    cyc(3); we_n = 1'b1;
    cyc(1); cs_n = 1'b1;
    cyc(6);
    bus_read(24'h0, 32'hCAFE_0001, "R7 capture at strobe start");

    // R6 / R9 read held across a write commit
    addr = 24'h0; din = 32'h5555_AAAA; cs_n = 1'b0; oe_n = 1'b0;
    cyc(1); we_n = 1'b0;
    cyc(8);
    expect_now(32'hCAFE_0001, "R6 held strobe keeps old value");
    cyc(1); we_n = 1'b1;
    cyc(7);
    expect_now(32'h5555_AAAA, "R9 new value during held read");
    cyc(1); oe_n = 1'b1; cs_n = 1'b1;
    cyc(6);

    // R5 enable needs both chip select and output enable
    cs_n = 1'b0; oe_n = 1'b1; cyc(6);
    chk("R5 cs only enable", DW'(dout_en), '0);
    chk("R5 cs only data", dout, '0);
    cs_n = 1'b1; oe_n = 1'b0; cyc(6);
    chk("R5 oe only enable", DW'(dout_en), '0);
    chk("R5 oe only data", dout, '0);
    oe_n = 1'b1; cyc(4);

    cyc(2);
    if (exp_q.size() != 0) begin
      fails++;
      checks++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule